// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Checked FIFO

This block receives characters from an idle-high asynchronous serial line. The line is oversampled with a 16x baud tick. A falling edge starts a character, and eight data bits arrive least significant bit first. An optional parity bit follows, then one or two stop bits. Each finished character is screened before it goes into a 16-entry receive FIFO. The screening looks for a bad stop bit, a full FIFO and a pending break. A character that fails any of these checks is dropped, and a sticky status flag records why. A parity mismatch does not drop the character: it is stored together with a per-entry parity error bit.

The CPU side reads the FIFO through a valid/ready stream. `rd_valid` is high whenever the FIFO holds an entry. `rd_data` and `rd_perr` show the oldest entry, and that entry is removed on any clock where both `rd_valid` and `rd_ready` are high. The reader may hold `rd_ready` low for as long as it likes. While it does, the receiver does not stall: a character that finds the FIFO full is lost and reported as an overrun.

There are three interrupt request outputs: data-full, error and break. All three are gated by one shared enable. The receiver keeps taking new characters after any error.

Top module: `uart_rx_chk`

## Requirements
- R1: With the receiver idle, a low level on `rxd` begins a start bit. The line is checked again 8 ticks later. If it reads high then, the event is a glitch: no character is produced and the receiver returns to idle.
- R2: Data bits are sampled at their middle tick, 16 ticks apart. The first data bit received lands in `rd_data[0]`. This holds whatever the spacing of `baud_tick16` pulses.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. The expected parity is even when `cfg_par_odd` is 0 and odd when it is 1. A mismatch stores the character with `rd_perr`=1, and a match stores it with `rd_perr`=0.
- R4: A valid character that arrives while the FIFO holds 16 entries is not stored and sets `st_overrun`. The entries already in the FIFO are left as they were.
- R5: A first stop bit sampled as 0 sets `st_frame_err` and the character is not stored. When `cfg_two_stop` is 1, the value of the second stop bit is ignored.
- R6: Break is a character whose data bits, parity bit (if enabled) and first stop bit are all 0. A break sets `st_break` and `st_frame_err`, and the receiver then waits for the line to go high before it looks for a new start bit. While `st_break` is set, well-formed characters are discarded.
- R7: No error stops reception. A good character that arrives after a framing error or an overrun is stored normally.
- R8: `rd_valid` is 1 exactly when `fifo_count` is not 0. Entries leave in arrival order, one on each clock where `rd_valid` and `rd_ready` are both high.
- R9: `st_full` is 1 while `fifo_count` is at least `cfg_trig`. The legal range of `cfg_trig` is 1 to 16.
- R10: `st_ready` is 1 when the FIFO holds at least one entry but fewer than `cfg_trig`, and the receiver has been idle for 15 character times. A character time is 16 ticks for each of start, data, parity (if enabled) and stop bits.
- R11: The interrupt outputs are each ANDed with `cfg_irq_en`:
  - `irq_rxi` follows (`st_full` OR `st_ready`).
  - `irq_eri` follows (`st_frame_err` OR `st_overrun`).
  - `irq_bri` follows `st_break`.
- R12: After reset the FIFO is empty and all flags and requests are 0. The error flags are sticky:
  - `clr_err` clears `st_frame_err` and `st_overrun`.
  - `clr_brk` clears `st_break`.
  - A new error in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits per character |
| cfg_trig | input | 5 | FIFO fill trigger level, 1..16 |
| cfg_irq_en | input | 1 | Shared interrupt enable |
| clr_err | input | 1 | Clear framing and overrun flags |
| clr_brk | input | 1 | Clear break flag |
| rd_valid | output | 1 | FIFO head is valid |
| rd_ready | input | 1 | Reader accepts head |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error bit |
| fifo_count | output | 5 | Entries held |
| st_full | output | 1 | Fill has reached trigger |
| st_ready | output | 1 | Data waiting after idle timeout |
| st_frame_err | output | 1 | Sticky framing error |
| st_overrun | output | 1 | Sticky overrun |
| st_break | output | 1 | Sticky break |
| irq_rxi | output | 1 | Data-full request |
| irq_eri | output | 1 | Error request |
| irq_bri | output | 1 | Break request |

## Verification
The embedded properties are checked on every cycle:
- the FIFO never writes while full and never reads while empty;
- a finished character is reported for only one cycle;
- a framing flag stays set until it is cleared;
- a good character that meets a full FIFO always raises overrun;
- no character reaches the FIFO while a break is pending.

Other behaviour only the bench scenarios can show, because it depends on what is sent over the line:
- the order in which bits are assembled and parity is computed;
- glitch rejection;
- the second stop bit being ignored;
- recovery after errors;
- the exact length of the idle timeout.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BITS, S_STOP, S_SKIP, S_WAITH
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              stop_ok;
    logic              all_zero;
  } rx_frame_t;
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line,
  input  logic      tick,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      two_stop,
  output logic      frm_valid,
  output rx_frame_t frm,
  output logic      idle
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] sh;
  logic              pbit;
  logic [BW-1:0]     last_idx;

  assign last_idx = par_en ? BW'(DATA_W) : BW'(DATA_W - 1);
  assign idle     = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      frm_valid <= 1'b0;
      frm       <= '0;
    end else begin
      frm_valid <= 1'b0;
      case (state)
        S_IDLE: if (tick && !line) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= line ? S_IDLE : S_BITS;
          end else cnt <= cnt + 1'b1;
        end
        S_BITS: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (bit_idx < BW'(DATA_W)) sh <= {line, sh[DATA_W-1:1]};
            else                       pbit <= line;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == last_idx) state <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == LAST) begin
            cnt            <= '0;
            frm_valid      <= 1'b1;
            frm.data       <= sh;
            frm.stop_ok    <= line;
            frm.perr       <= par_en & (^sh ^ pbit ^ par_odd);
            frm.all_zero   <= (sh == '0) && !(par_en && pbit) && !line;
            if (!line)         state <= S_WAITH;
            else if (two_stop) state <= S_SKIP;
            else               state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_SKIP: if (tick) begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= S_WAITH;
          end else cnt <= cnt + 1'b1;
        end
        S_WAITH: if (line) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_CYCLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid); // R2
  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick && cnt == MID && line) |=> (state == S_IDLE && !frm_valid)); // R1
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PMAX) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PMAX) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH))); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R8
endmodule

// File: rtl/urx_timeout.sv
module urx_timeout #(
  parameter int OSR        = 16,
  parameter int TOUT_CHARS = 15,
  parameter int DW         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic tick,
  input  logic par_en,
  input  logic two_stop,
  output logic expired
);
  localparam int MAXT = TOUT_CHARS * OSR * (DW + 4);
  localparam int TW   = $clog2(MAXT + 1);

  logic [TW-1:0] cnt, limit;

  always_comb begin
    case ({par_en, two_stop})
      2'b00:   limit = TW'(TOUT_CHARS * OSR * (DW + 2));
      2'b11:   limit = TW'(TOUT_CHARS * OSR * (DW + 4));
      default: limit = TW'(TOUT_CHARS * OSR * (DW + 3));
    endcase
  end

  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!idle)                cnt <= '0;
    else if (tick && cnt < limit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OSR        = 16,
  parameter int TOUT_CHARS = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxd,
  input  logic                       baud_tick16,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       cfg_two_stop,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_trig,
  input  logic                       cfg_irq_en,
  input  logic                       clr_err,
  input  logic                       clr_brk,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_perr,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       st_full,
  output logic                       st_ready,
  output logic                       st_frame_err,
  output logic                       st_overrun,
  output logic                       st_break,
  output logic                       irq_rxi,
  output logic                       irq_eri,
  output logic                       irq_bri
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 1;

  logic      rxd_m, rxd_s;
  logic      frm_valid, rx_idle, tout;
  rx_frame_t frm;
  logic      push, pop, fifo_full, good_char;
  logic [EW-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  urx_sampler #(.OSR(OSR)) sampler_i (
    .clk(clk), .rst_n(rst_n), .line(rxd_s), .tick(baud_tick16),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
    .frm_valid(frm_valid), .frm(frm), .idle(rx_idle)
  );

  urx_timeout #(.OSR(OSR), .TOUT_CHARS(TOUT_CHARS), .DW(DATA_W)) timeout_i (
    .clk(clk), .rst_n(rst_n), .idle(rx_idle), .tick(baud_tick16),
    .par_en(cfg_par_en), .two_stop(cfg_two_stop), .expired(tout)
  );

  assign fifo_full = (fifo_count == CW'(DEPTH));
  assign good_char = frm_valid && frm.stop_ok && !frm.all_zero && !st_break;
  assign push      = good_char && !fifo_full;
  assign pop       = rd_valid && rd_ready;

  urx_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata({frm.perr, frm.data}),
    .pop(pop), .rdata(head), .count(fifo_count)
  );

  assign rd_valid = (fifo_count != '0);
  assign rd_data  = head[DATA_W-1:0];
  assign rd_perr  = head[DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_frame_err <= 1'b0;
      st_overrun   <= 1'b0;
      st_break     <= 1'b0;
    end else begin
      if (frm_valid && !frm.stop_ok)   st_frame_err <= 1'b1;
      else if (clr_err)                st_frame_err <= 1'b0;
      if (good_char && fifo_full)      st_overrun   <= 1'b1;
      else if (clr_err)                st_overrun   <= 1'b0;
      if (frm_valid && frm.all_zero)   st_break     <= 1'b1;
      else if (clr_brk)                st_break     <= 1'b0;
    end
  end

  assign st_full  = (fifo_count >= cfg_trig);
  assign st_ready = tout && (fifo_count != '0) && (fifo_count < cfg_trig);
  assign irq_rxi  = cfg_irq_en && (st_full || st_ready);
  assign irq_eri  = cfg_irq_en && (st_frame_err || st_overrun);
  assign irq_bri  = cfg_irq_en && st_break;

  AST_BRK_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_break && frm_valid && !pop) |=> (fifo_count == $past(fifo_count))); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm.stop_ok && !frm.all_zero && !st_break && fifo_count == CW'(DEPTH))
      |=> st_overrun); // R4
  AST_FER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_frame_err && !clr_err) |=> st_frame_err); // R12
endmodule

// File: tb/uart_rx_chk_tb.sv
`timescale 1ns/1ps
module uart_rx_chk_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0;
  logic par_en = 0, par_odd = 0, two_stop = 0, irq_en = 0;
  logic [4:0] trig = 5'd16;
  logic clr_err = 0, clr_brk = 0, rd_ready = 0;
  logic rd_valid, rd_perr, st_full, st_ready, st_fer, st_ore, st_brk;
  logic irq_rxi, irq_eri, irq_bri;
  logic [7:0] rd_data;
  logic [4:0] fifo_count;

  int checks = 0, failures = 0;
  int tick_div = 1, tick_cnt = 0;
  bit m_brk = 0;
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  uart_rx_chk dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick16(tick),
    .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_two_stop(two_stop),
    .cfg_trig(trig), .cfg_irq_en(irq_en), .clr_err(clr_err), .clr_brk(clr_brk),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_perr(rd_perr),
    .fifo_count(fifo_count), .st_full(st_full), .st_ready(st_ready),
    .st_frame_err(st_fer), .st_overrun(st_ore), .st_break(st_brk),
    .irq_rxi(irq_rxi), .irq_eri(irq_eri), .irq_bri(irq_bri)
  );

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin tick_cnt <= 0; tick <= 1'b1; end
    else begin tick_cnt <= tick_cnt + 1; tick <= 1'b0; end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd, input logic bad);
    return ^d ^ odd ^ bad;
  endfunction

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (16 * tick_div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad, input logic s1, input logic s2);
    logic p;
    bit zero;
    p = par_bit(d, par_odd, bad);
    zero = (d == 8'h00) && !(par_en && p) && !s1;
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(d[i]);
    if (par_en) bit_time(p);
    bit_time(s1);
    if (two_stop) bit_time(s2);
    bit_time(1'b1);
    bit_time(1'b1);
    if (zero) m_brk = 1;
    else if (s1 && !m_brk && exp_q.size() < 16) exp_q.push_back({par_en & bad, d});
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      logic [8:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      check({req, " rd_valid"}, rd_valid, 1);
      check({req, " head"}, {rd_perr, rd_data}, e);
      rd_ready = 1;
      @(negedge clk);
      rd_ready = 0;
    end
    @(negedge clk);
    check({req, " empty"}, rd_valid, 0);
  endtask

  task automatic pulse_clear(input bit e, input bit b);
    @(negedge clk);
    clr_err = e; clr_brk = b;
    @(negedge clk);
    clr_err = 0; clr_brk = 0;
    if (b) m_brk = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 rd_valid", rd_valid, 0);
    check("R12 flags", {st_full, st_ready, st_fer, st_ore, st_brk}, 0);
    check("R12 irqs", {irq_rxi, irq_eri, irq_bri}, 0);

    // R1 glitch shorter than half a bit
    rxd = 0; repeat (5) @(negedge clk); rxd = 1;
    repeat (100) @(negedge clk);
    check("R1 glitch no data", rd_valid, 0);
    check("R1 glitch no error", st_fer, 0);

    // R2 R3 R8 random characters under random framing
    for (int r = 0; r < 4; r++) begin
      par_en = $urandom_range(0, 1); par_odd = $urandom_range(0, 1);
      two_stop = $urandom_range(0, 1);
      for (int k = 0; k < 6; k++)
        send(8'($urandom), par_en && ($urandom_range(0, 3) == 0), 1'b1, 1'b1);
      send(8'h80, 1'b0, 1'b1, 1'b1);
      if (par_en) send(8'h01, 1'b1, 1'b1, 1'b1);
      drain("R2 R3 R8 random");
    end
    par_en = 0; two_stop = 0;

    // R9 R11 trigger level
    trig = 5'd4; irq_en = 1;
    for (int k = 0; k < 3; k++) send(8'h10 + 8'(k), 0, 1, 1);
    check("R9 below trigger", st_full, 0);
    send(8'h13, 0, 1, 1);
    check("R9 at trigger", st_full, 1);
    check("R11 rxi", irq_rxi, 1);
    drain("R8 trig");

    // R4 overrun
    trig = 5'd16;
    for (int k = 0; k < 16; k++) send(8'($urandom), 0, 1, 1);
    check("R4 count full", fifo_count, 16);
    check("R4 no overrun yet", st_ore, 0);
    send(8'hEE, 0, 1, 1);
    check("R4 overrun", st_ore, 1);
    check("R11 eri", irq_eri, 1);
    drain("R4 contents");
    pulse_clear(1, 0);
    check("R12 clr_err", st_ore, 0);

    // R5 R7 framing error then recovery
    send(8'h5A, 0, 1'b0, 1);
    check("R5 fer set", st_fer, 1);
    check("R5 not stored", rd_valid, 0);
    send(8'h33, 0, 1, 1);
    drain("R7 after fer");
    pulse_clear(1, 0);
    check("R12 fer cleared", st_fer, 0);

    // R5 second stop bit ignored
    two_stop = 1;
    send(8'hC3, 0, 1, 1'b0);
    check("R5 stop2 ignored", st_fer, 0);
    send(8'h3C, 0, 1, 1);
    drain("R5 two stop");
    two_stop = 0;

    // R6 break
    irq_en = 0;
    send(8'h00, 0, 1'b0, 1);
    check("R6 break flag", st_brk, 1);
    check("R6 break fer", st_fer, 1);
    check("R11 bri gated", irq_bri, 0);
    irq_en = 1; @(negedge clk);
    check("R11 bri", irq_bri, 1);
    send(8'h77, 0, 1, 1);
    check("R6 discard in break", rd_valid, 0);
    pulse_clear(1, 1);
    check("R12 clr_brk", st_brk, 0);
    send(8'h77, 0, 1, 1);
    drain("R6 after clear");

    // R10 idle timeout
    trig = 5'd8;
    send(8'h21, 0, 1, 1);
    send(8'h22, 0, 1, 1);
    check("R10 not yet", st_ready, 0);
    repeat (2100) @(negedge clk);
    check("R10 before limit", st_ready, 0);
    repeat (400) @(negedge clk);
    check("R10 ready", st_ready, 1);
    check("R11 rxi ready", irq_rxi, 1);
    drain("R10 pop");
    check("R10 cleared", st_ready, 0);

    // R2 slower tick spacing
    tick_div = 3;
    send(8'hA5, 0, 1, 1);
    drain("R2 slow tick");
    tick_div = 1;

    summary();
  end
endmodule